// File: doc/BRIEF.md
# Legacy DMA Channel Address and Count Register File

This block keeps the programmable address and count state for four DMA channels behind a narrow 8-bit port. The port carries one byte at a time. A single byte-pointer toggle decides whether an access reaches the low or the high half of a 16-bit register. For every channel the block keeps:

- a base address and a base count, both programmed by software;
- a current address, reloaded from the base address when the high byte of either register is written;
- a progress count, loaded by the transfer engine while that channel holds the grant.

Readback is live. Software sees the current address moved forward or back by the progress count, and the remaining count. A separate page bank holds a page byte and an optional upper page byte for each channel. The page bank uses the sparse port-offset mapping that legacy software expects.

The controller that owns the mode, mask and arbitration ports feeds three things in: the direction bit of each channel, the grant, and a request to clear the byte pointer. For the granted channel the block returns the full physical transfer address and the programmed transfer length. The `DSHIFT` parameter selects the word-wide variant. In that variant the port address is decoded one bit higher, addresses and counts are kept in 2-byte units shifted left by one, and the length is doubled.

Top module: `dma_chan_regs`

## Requirements
- R1: After a synchronous active-low reset, all of these are zero: every base, current, progress and page register, and the byte pointer. With `grant_ch` = 0, `phys_addr` reads 0 and `xfer_len` reads 1.
- R2: The slot index is `(io_addr >> DSHIFT) & 0xF`. Bits [2:1] of the index pick the channel. Bit 0 picks the register: 0 is address, 1 is count. An access whose index has bit 3 set changes no register and does not move the byte pointer.
- R3: One byte pointer is shared by all channels and by both reads and writes. Each in-range access uses its current value and then inverts it. A value of 0 selects bits [7:0] and 1 selects bits [15:8].
- R4: `clear_ff` forces the byte pointer to 0 on the next edge and overrides the toggle of a simultaneous access. That access still uses the old pointer value.
- R5: A write with the pointer at 0 replaces bits [7:0] of the selected base register. A write with the pointer at 1 replaces bits [15:8]. The other byte is unchanged.
- R6: A high-byte write to either register of a channel reloads that channel. The current address becomes the new base address shifted left by `DSHIFT`, and the progress count becomes 0.
- R7: A count read returns byte `ptr` of `(base_count << DSHIFT) - progress`, after a further right shift of `DSHIFT`.
- R8: An address read returns `current + progress` when the channel's `mode_dec` bit is 0, and `current - progress` when it is 1. The byte is selected as in R7.
- R9: `prog_in` is captured only by the channel named by `grant_ch`, and only while `grant_valid` is 1. The progress of every other channel holds.
- R10: Page offsets 1, 2, 3 and 7 select channels 2, 3, 1 and 0. `pg_hi` = 1 selects the upper page byte instead of the page byte. Writes to any other offset change nothing. Reads from any other offset return 0.
- R11: `phys_addr` equals `{upper_page[6:0], page[7:0], current_address[15:0]}` of the channel on `grant_ch`.
- R12: `xfer_len` equals `(base_count + 1) << DSHIFT` for the channel on `grant_ch`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 4+DSHIFT | Port address of a channel-register access |
| chan_wr | input | 1 | Write strobe for the channel registers |
| chan_rd | input | 1 | Read strobe for the channel registers; advances the byte pointer |
| wdata | input | 8 | Write byte for channel and page registers |
| chan_rdata | output | 8 | Byte read from the addressed channel register at the current pointer |
| clear_ff | input | 1 | Forces the byte pointer to the low byte |
| pg_wr | input | 1 | Page-register write strobe |
| pg_hi | input | 1 | Selects the upper page byte instead of the page byte |
| pg_off | input | 3 | Page port offset |
| pg_rdata | output | 8 | Byte read from the addressed page register |
| mode_dec | input | 4 | Per-channel address-decrement direction bit |
| grant_valid | input | 1 | Transfer engine holds a grant this cycle |
| grant_ch | input | 2 | Granted channel |
| prog_in | input | 16+DSHIFT | Progress count from the transfer engine |
| phys_addr | output | 31 | Physical transfer address of the granted channel |
| xfer_len | output | 17+DSHIFT | Programmed transfer length of the granted channel |

## Verification
If the byte pointer is wrong, every following byte read comes back swapped. This shows at `chan_rdata` on the very next read, so reads are issued in pairs and compared byte by byte. A wrong reload or a wrong progress capture shows up in readback of the address and count: it is visible in the first read after the write or the grant cycle, whatever the pointer value. A page decode error shows in `pg_rdata` and `phys_addr` in the same cycle the offset is presented. A write to an unmapped offset that lands anyway shows at the next read of the mapped offsets.

// File: rtl/dma_chan_pkg.sv
`timescale 1ns/1ps
// Shared constants and the page-port decode for the DMA channel register file.
// Assumes a fixed four-channel controller.
package dma_chan_pkg;

    localparam int CH_NUM = 4;
    localparam int CH_W   = 2;

    typedef struct packed {
        logic            hit;
        logic [CH_W-1:0] ch;
    } page_map_t;

    // Map a sparse page port offset onto a channel number.
    function automatic page_map_t page_decode(input logic [2:0] off);
        page_map_t m;
        m.hit = 1'b1;
        m.ch  = '0;
        case (off)
            3'd1:    m.ch = 2'd2;
            3'd2:    m.ch = 2'd3;
            3'd3:    m.ch = 2'd1;
            3'd7:    m.ch = 2'd0;
            default: m.hit = 1'b0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dma_ptr_ff.sv
`timescale 1ns/1ps
// Byte-pointer toggle shared by all channel-register accesses.
// Assumes 'access' is already qualified to the in-range channel slots.
// Clear wins over the toggle.
module dma_ptr_ff (
    input  logic clk,
    input  logic rst_n,
    input  logic access,
    input  logic clear,
    output logic ptr
);

    // Flip on every access, return to the low byte on clear or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr <= 1'b0;
        else if (clear)  ptr <= 1'b0;
        else if (access) ptr <= ~ptr;
    end

    assert_ptr_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !clear) |=> (ptr != $past(ptr)));

    assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!access && !clear) |=> $stable(ptr));

    assert_ptr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !ptr);

endmodule

// File: rtl/dma_chan_slot.sv
`timescale 1ns/1ps
// State of one channel: the base address and base count, the current address
// and the progress count. Also computes the live address and count readback
// values. Assumes 'wr_en' is already qualified to this channel.
module dma_chan_slot #(
    parameter int DSHIFT = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 sel,
    input  logic                 hi,
    input  logic [7:0]           wdata,
    input  logic                 prog_we,
    input  logic [16+DSHIFT-1:0] prog_in,
    input  logic                 dec,
    output logic [15:0]          base_cnt,
    output logic [16+DSHIFT-1:0] cur_addr,
    output logic [17+DSHIFT-1:0] addr_val,
    output logic [17+DSHIFT-1:0] cnt_val
);

    localparam int AW = 16 + DSHIFT;
    localparam int VW = 17 + DSHIFT;

    logic [15:0]   base_addr;
    logic [15:0]   nxt_base_addr;
    logic [15:0]   nxt_base_cnt;
    logic [AW-1:0] prog;
    logic          reload;

    assign reload = wr_en && hi;

    // Next base values with the written byte merged into the selected register.
    always_comb begin
        nxt_base_addr = base_addr;
        nxt_base_cnt  = base_cnt;
        if (wr_en && !sel) begin
            if (hi) nxt_base_addr[15:8] = wdata;
            else    nxt_base_addr[7:0]  = wdata;
        end
        if (wr_en && sel) begin
            if (hi) nxt_base_cnt[15:8] = wdata;
            else    nxt_base_cnt[7:0]  = wdata;
        end
    end

    // Base registers take the merged byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            base_cnt  <= '0;
        end else begin
            base_addr <= nxt_base_addr;
            base_cnt  <= nxt_base_cnt;
        end
    end

    // Current address reloads from the new base on a high-byte write.
    always_ff @(posedge clk) begin
        if (!rst_n)      cur_addr <= '0;
        else if (reload) cur_addr <= AW'(nxt_base_addr) << DSHIFT;
    end

    // Progress clears on reload, otherwise follows the engine while granted.
    always_ff @(posedge clk) begin
        if (!rst_n)       prog <= '0;
        else if (reload)  prog <= '0;
        else if (prog_we) prog <= prog_in;
    end

    // Live readback values.
    always_comb begin
        addr_val = dec ? (VW'(cur_addr) - VW'(prog)) : (VW'(cur_addr) + VW'(prog));
        cnt_val  = (VW'(base_cnt) << DSHIFT) - VW'(prog);
    end

    assert_low_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hi && !sel) |=>
            (base_addr[15:8] == $past(base_addr[15:8])) && (base_addr[7:0] == $past(wdata)));

    assert_high_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hi && sel) |=>
            (base_cnt[7:0] == $past(base_cnt[7:0])) && (base_cnt[15:8] == $past(wdata)));

    assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (prog == '0) && (cur_addr == (AW'(base_addr) << DSHIFT)));

    assert_prog_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_we && !reload) |=> $stable(prog));

endmodule

// File: rtl/dma_page_bank.sv
`timescale 1ns/1ps
// Page and upper-page bytes for each channel, reached through sparse offsets.
// Unmapped offsets ignore writes and read as zero. The upper bank exists only
// when HIGH_PAGE_EN is set.
module dma_page_bank
    import dma_chan_pkg::*;
#(
    parameter bit HIGH_PAGE_EN = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pg_wr,
    input  logic                   pg_hi,
    input  logic [2:0]             pg_off,
    input  logic [7:0]             wdata,
    output logic [7:0]             pg_rdata,
    output logic [CH_NUM-1:0][7:0] page_q,
    output logic [CH_NUM-1:0][7:0] hpage_q
);

    page_map_t m;
    assign m = page_decode(pg_off);

    // Low page bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)                    page_q       <= '0;
        else if (pg_wr && m.hit && !pg_hi) page_q[m.ch] <= wdata;
    end

    generate
        if (HIGH_PAGE_EN) begin : g_hpage
            // Upper page bytes.
            always_ff @(posedge clk) begin
                if (!rst_n)                        hpage_q       <= '0;
                else if (pg_wr && m.hit && pg_hi)  hpage_q[m.ch] <= wdata;
            end
        end else begin : g_no_hpage
            assign hpage_q = '0;
        end
    endgenerate

    // Readback of the addressed byte, zero for unmapped offsets.
    always_comb begin
        if (!m.hit)     pg_rdata = 8'h00;
        else if (pg_hi) pg_rdata = hpage_q[m.ch];
        else            pg_rdata = page_q[m.ch];
    end

    assert_page_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_wr && !m.hit) |=> ($stable(page_q) && $stable(hpage_q)));

endmodule

// File: rtl/dma_chan_regs.sv
`timescale 1ns/1ps
// Channel address/count register file of a four-channel DMA controller.
// Decodes byte accesses from the port, steers them through the shared byte
// pointer, and presents readback, the physical address and the length of the
// granted channel. Mode, mask and arbitration live in the parent controller.
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int DSHIFT       = 0,
    parameter bit HIGH_PAGE_EN = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [4+DSHIFT-1:0]  io_addr,
    input  logic                 chan_wr,
    input  logic                 chan_rd,
    input  logic [7:0]           wdata,
    output logic [7:0]           chan_rdata,
    input  logic                 clear_ff,
    input  logic                 pg_wr,
    input  logic                 pg_hi,
    input  logic [2:0]           pg_off,
    output logic [7:0]           pg_rdata,
    input  logic [CH_NUM-1:0]    mode_dec,
    input  logic                 grant_valid,
    input  logic [CH_W-1:0]      grant_ch,
    input  logic [16+DSHIFT-1:0] prog_in,
    output logic [30:0]          phys_addr,
    output logic [17+DSHIFT-1:0] xfer_len
);

    localparam int AW = 16 + DSHIFT;
    localparam int VW = 17 + DSHIFT;

    logic [3:0]                idx;
    logic                      in_range;
    logic [CH_W-1:0]           sel_ch;
    logic                      sel_reg;
    logic                      ptr;
    logic [CH_NUM-1:0][15:0]   base_cnt;
    logic [CH_NUM-1:0][AW-1:0] cur_addr;
    logic [CH_NUM-1:0][VW-1:0] addr_val;
    logic [CH_NUM-1:0][VW-1:0] cnt_val;
    logic [CH_NUM-1:0][7:0]    page_q;
    logic [CH_NUM-1:0][7:0]    hpage_q;
    logic [VW-1:0]             sel_val;
    logic [VW-1:0]             shifted;

    // Slot decode of the port address.
    assign idx      = io_addr[DSHIFT +: 4];
    assign in_range = !idx[3];
    assign sel_ch   = idx[2:1];
    assign sel_reg  = idx[0];

    dma_ptr_ff u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .access ((chan_wr || chan_rd) && in_range),
        .clear  (clear_ff),
        .ptr    (ptr)
    );

    generate
        for (genvar i = 0; i < CH_NUM; i++) begin : g_ch
            dma_chan_slot #(.DSHIFT(DSHIFT)) u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (chan_wr && in_range && (sel_ch == CH_W'(i))),
                .sel      (sel_reg),
                .hi       (ptr),
                .wdata    (wdata),
                .prog_we  (grant_valid && (grant_ch == CH_W'(i))),
                .prog_in  (prog_in),
                .dec      (mode_dec[i]),
                .base_cnt (base_cnt[i]),
                .cur_addr (cur_addr[i]),
                .addr_val (addr_val[i]),
                .cnt_val  (cnt_val[i])
            );
        end
    endgenerate

    dma_page_bank #(.HIGH_PAGE_EN(HIGH_PAGE_EN)) u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .pg_wr    (pg_wr),
        .pg_hi    (pg_hi),
        .pg_off   (pg_off),
        .wdata    (wdata),
        .pg_rdata (pg_rdata),
        .page_q   (page_q),
        .hpage_q  (hpage_q)
    );

    // Byte selection of the addressed readback value.
    always_comb begin
        sel_val    = sel_reg ? cnt_val[sel_ch] : addr_val[sel_ch];
        shifted    = ptr ? (sel_val >> (DSHIFT + 8)) : (sel_val >> DSHIFT);
        chan_rdata = in_range ? shifted[7:0] : 8'h00;
    end

    // Transfer address and length of the granted channel.
    always_comb begin
        phys_addr = {hpage_q[grant_ch][6:0], page_q[grant_ch], cur_addr[grant_ch][15:0]};
        xfer_len  = (VW'(base_cnt[grant_ch]) + VW'(1)) << DSHIFT;
    end

    assert_oor_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((chan_wr || chan_rd) && !in_range && !clear_ff) |=> $stable(ptr));

    assert_oor_regs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_wr && !in_range) |=> ($stable(base_cnt) && $stable(cur_addr)));

endmodule

// File: tb/dma_chan_regs_tb.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table of byte writes and reads, followed by
// directed tests for reset, progress, reload, pointer and page corner cases.
module dma_chan_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  io_addr = '0;
    logic        chan_wr = 1'b0;
    logic        chan_rd = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  chan_rdata;
    logic        clear_ff = 1'b0;
    logic        pg_wr = 1'b0;
    logic        pg_hi = 1'b0;
    logic [2:0]  pg_off = '0;
    logic [7:0]  pg_rdata;
    logic [3:0]  mode_dec = '0;
    logic        grant_valid = 1'b0;
    logic [1:0]  grant_ch = '0;
    logic [15:0] prog_in = '0;
    logic [30:0] phys_addr;
    logic [16:0] xfer_len;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    dma_chan_regs u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .chan_wr(chan_wr),
        .chan_rd(chan_rd), .wdata(wdata), .chan_rdata(chan_rdata),
        .clear_ff(clear_ff), .pg_wr(pg_wr), .pg_hi(pg_hi), .pg_off(pg_off),
        .pg_rdata(pg_rdata), .mode_dec(mode_dec), .grant_valid(grant_valid),
        .grant_ch(grant_ch), .prog_in(prog_in), .phys_addr(phys_addr),
        .xfer_len(xfer_len)
    );

    // Entry: bit 12 = read-and-compare, [11:8] = slot index, [7:0] = byte.
    localparam int NVEC = 20;
    localparam logic [15:0] VEC [NVEC] = '{
        16'h0234, 16'h0212, 16'h030F, 16'h0300, 16'h1234, 16'h1212, 16'h130F, 16'h1300,
        16'h04AB, 16'h04CD, 16'h14AB, 16'h14CD, 16'h07FF, 16'h07FF, 16'h17FF, 16'h17FF,
        16'h0001, 16'h0080, 16'h1001, 16'h1080
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cwrite(input logic [3:0] idx, input logic [7:0] d);
        @(negedge clk);
        io_addr = idx; wdata = d; chan_wr = 1'b1;
        @(negedge clk);
        chan_wr = 1'b0;
    endtask

    task automatic cread(input logic [3:0] idx, output logic [7:0] d, input bit clr = 1'b0);
        @(negedge clk);
        io_addr = idx; chan_rd = 1'b1; clear_ff = clr;
        #1 d = chan_rdata;
        @(negedge clk);
        chan_rd = 1'b0; clear_ff = 1'b0;
    endtask

    task automatic pwrite(input bit hi, input logic [2:0] off, input logic [7:0] d);
        @(negedge clk);
        pg_hi = hi; pg_off = off; wdata = d; pg_wr = 1'b1;
        @(negedge clk);
        pg_wr = 1'b0;
    endtask

    task automatic pread(input bit hi, input logic [2:0] off, output logic [7:0] d);
        @(negedge clk);
        pg_hi = hi; pg_off = off;
        #1 d = pg_rdata;
    endtask

    task automatic grant(input logic [1:0] ch, input logic [15:0] p);
        @(negedge clk);
        grant_ch = ch; prog_in = p; grant_valid = 1'b1;
        @(negedge clk);
        grant_valid = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clear_ff = 1'b1;
        @(negedge clk);
        clear_ff = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1;
        check("R1 phys_addr", 32'(phys_addr), 32'h0);
        check("R1 xfer_len", 32'(xfer_len), 32'h1);
        cread(4'h3, b); check("R1 count low", 32'(b), 32'h00);
        cread(4'h3, b); check("R1 count high", 32'(b), 32'h00);
        pread(1'b0, 3'd7, b); check("R1 page", 32'(b), 32'h00);

        // R3 R5: table of byte writes and reads
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][12]) begin
                cread(VEC[i][11:8], b);
                check($sformatf("R3/R5 vector %0d", i), 32'(b), 32'(VEC[i][7:0]));
            end else begin
                cwrite(VEC[i][11:8], VEC[i][7:0]);
            end
        end

        // R8: address readback, incrementing and decrementing
        grant(2'd1, 16'd5);
        cread(4'h2, b); check("R8 inc low", 32'(b), 32'h39);
        cread(4'h2, b); check("R8 inc high", 32'(b), 32'h12);
        mode_dec[1] = 1'b1;
        cread(4'h2, b); check("R8 dec low", 32'(b), 32'h2F);
        cread(4'h2, b); check("R8 dec high", 32'(b), 32'h12);
        mode_dec[1] = 1'b0;
        // R7: remaining count
        cread(4'h3, b); check("R7 count low", 32'(b), 32'h0A);
        cread(4'h3, b); check("R7 count high", 32'(b), 32'h00);

        // R9: a grant to channel 2 leaves channel 1 progress alone
        grant(2'd2, 16'd7);
        cread(4'h3, b); check("R9 other ch low", 32'(b), 32'h0A);
        cread(4'h3, b); check("R9 other ch high", 32'(b), 32'h00);

        // R6: a low write does not reload; the high write does
        cwrite(4'h3, 8'h20);
        pulse_clear();
        cread(4'h3, b); check("R6 no reload on low", 32'(b), 32'h1B);
        cread(4'h3, b); check("R6 no reload high", 32'(b), 32'h00);
        cwrite(4'h3, 8'h20);
        cwrite(4'h3, 8'h00);
        cread(4'h3, b); check("R6 reload count low", 32'(b), 32'h20);
        cread(4'h3, b); check("R6 reload count high", 32'(b), 32'h00);
        cread(4'h2, b); check("R6 reload addr low", 32'(b), 32'h34);
        cread(4'h2, b); check("R6 reload addr high", 32'(b), 32'h12);

        // R2: slot index with bit 3 set is ignored and keeps the pointer
        cwrite(4'hA, 8'h55);
        cread(4'h2, b); check("R2 ignored low", 32'(b), 32'h34);
        cread(4'h2, b); check("R2 ignored high", 32'(b), 32'h12);

        // R4: clear alone, and clear on the same cycle as a read
        cread(4'h2, b);
        pulse_clear();
        cread(4'h2, b); check("R4 clear then low", 32'(b), 32'h34);
        cread(4'h2, b, 1'b1); check("R4 read during clear", 32'(b), 32'h12);
        cread(4'h2, b); check("R4 low after clear", 32'(b), 32'h34);
        cread(4'h2, b);

        // R10: page decode, unmapped offsets
        pwrite(1'b0, 3'd3, 8'h56);
        pwrite(1'b1, 3'd3, 8'hFF);
        pwrite(1'b0, 3'd7, 8'h9A);
        pwrite(1'b0, 3'd1, 8'h11);
        pwrite(1'b0, 3'd5, 8'h77);
        pwrite(1'b1, 3'd0, 8'h66);
        pread(1'b0, 3'd5, b); check("R10 unmapped read", 32'(b), 32'h00);
        pread(1'b0, 3'd3, b); check("R10 ch1 page", 32'(b), 32'h56);
        pread(1'b1, 3'd3, b); check("R10 ch1 upper", 32'(b), 32'hFF);
        pread(1'b0, 3'd1, b); check("R10 ch2 page", 32'(b), 32'h11);
        pread(1'b0, 3'd2, b); check("R10 ch3 page untouched", 32'(b), 32'h00);
        pread(1'b1, 3'd7, b); check("R10 ch0 upper untouched", 32'(b), 32'h00);

        // R11 R12: granted channel address and length
        @(negedge clk); grant_ch = 2'd1; #1;
        check("R11 ch1 phys", 32'(phys_addr), 32'h7F561234);
        check("R12 ch1 length", 32'(xfer_len), 32'h21);
        @(negedge clk); grant_ch = 2'd0; #1;
        check("R11 ch0 phys", 32'(phys_addr), 32'h009A8001);
        @(negedge clk); grant_ch = 2'd3; #1;
        check("R12 ch3 length", 32'(xfer_len), 32'h10000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule